// File: doc/BRIEF.md
# SPI Receive Status and Overflow Flags

This block holds the receive-side status of an SPI peripheral as a CPU sees it through two registers. The shift engine gives it a one-cycle strobe and the assembled byte each time a byte finishes. The first byte that arrives while the buffer is free is stored and raises a receive-full flag. A byte that arrives while that flag is still set is dropped, the older unread byte stays in the buffer, and an overflow flag is raised.

Software clears the flags with an ordered pair of reads. The first read is of the status register and arms a clear for each flag that is set at that moment. The following data register read then clears the armed flags. A bus write, or a status read that finds a flag low, cancels that flag's pending clear. The block drives one shared interrupt request. Receive-full reaches it through its own enable. Overflow and an external mode-fault flag, which another block detects, reach it together through a single error enable.

Top module: `spi_rx_status`

## Requirements
- R1: A byte strobe while receive-full is low writes the byte into the buffer and sets receive-full on the next clock edge.
- R2: A byte strobe while receive-full is high and not being cleared in that cycle sets overflow and leaves the buffer holding the earlier byte.
- R3: Receive-full clears on a data register read only if the last status read before it, with no bus write since, saw receive-full set.
- R4: Overflow clears on a data register read only if the last status read before it, with no bus write since, saw overflow set.
- R5: Arming is per flag. A status read arms only the flags that are set at that read, so a flag that rises afterwards survives the next data read.
- R6: Any bus write cancels all pending clears. A data read with nothing armed changes no flag.
- R7: The interrupt request contains receive-full only when the receive enable (status bit 0) is 1.
- R8: Overflow and the mode-fault input raise the interrupt request only through the single error enable (status bit 1). Neither can be enabled on its own.
- R9: After a synchronous reset (rst_n low at a clock edge), both flags are clear, nothing is armed, both enables are 0, the buffer reads 0 and the request is low.
- R10: Address 0 is status and address 1 is data. Status reads back as bit 7 receive-full, bit 6 overflow, bit 4 mode-fault input, bit 1 error enable, bit 0 receive enable, and all other bits 0. A write to status loads the two enables from bits 1:0.
- R11: A byte strobe in the same cycle as a data read that clears receive-full is loaded as a new byte. It does not cause an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_done | input | 1 | One-cycle strobe: a received byte is complete |
| byte_in | input | DATA_W | The received byte |
| bus_addr | input | 1 | Register select: 0 status, 1 data |
| bus_rd | input | 1 | Read strobe, one per access |
| bus_wr | input | 1 | Write strobe, one per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register (combinational) |
| fault_in | input | 1 | Mode-fault flag from the fault detector |
| irq | output | 1 | Shared receive/error interrupt request |

## Verification
The hardest situation to reach is a flag that changes between the two reads of a clear sequence. For example, overflow rises after a status read that armed only receive-full, or a byte lands in the very cycle of the clearing data read. The stimulus table places byte strobes between the status read and the data read on purpose, and it adds bus writes inside open sequences. It then reads status back to show which flags survived. A directed test drives a byte strobe in the same cycle as the clearing data read.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;
  localparam int ST_FULL_BIT = 7;
  localparam int ST_OVR_BIT  = 6;
  localparam int ST_FLT_BIT  = 4;
  localparam int ST_EIE_BIT  = 1;
  localparam int ST_RIE_BIT  = 0;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_DATA   = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic full;
    logic ovr;
  } rx_flags_t;

  // Build the 8-bit status image from its individual fields.
  function automatic logic [7:0] pack_status(input logic full, input logic ovr,
                                             input logic flt, input logic eie,
                                             input logic rie);
    logic [7:0] s;
    s = '0;
    s[ST_FULL_BIT] = full;
    s[ST_OVR_BIT]  = ovr;
    s[ST_FLT_BIT]  = flt;
    s[ST_EIE_BIT]  = eie;
    s[ST_RIE_BIT]  = rie;
    return s;
  endfunction

  // Combined interrupt request.
  function automatic logic irq_of(input logic full, input logic ovr, input logic flt,
                                  input logic rie, input logic eie);
    return (full & rie) | ((ovr | flt) & eie);
  endfunction
endpackage

// File: rtl/spi_rxs_arm.sv
module spi_rxs_arm
  import spi_rxs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      st_rd,
  input  logic      dt_rd,
  input  logic      any_wr,
  input  rx_flags_t flags,
  output rx_flags_t clr
);
  rx_flags_t armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      armed_q <= '0;
    else if (any_wr) armed_q <= '0;
    else if (st_rd)  armed_q <= flags;
    else if (dt_rd)  armed_q <= '0;
  end

  assign clr.full = dt_rd & armed_q.full;
  assign clr.ovr  = dt_rd & armed_q.ovr;

  assert_write_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> (armed_q == '0));
  assert_arm_follows_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !any_wr) |=> (armed_q == $past(flags)));
endmodule

// File: rtl/spi_rxs_flags.sv
module spi_rxs_flags
  import spi_rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  input  rx_flags_t         clr,
  output rx_flags_t         flags,
  output logic [DATA_W-1:0] rx_buf,
  output logic              load_evt,
  output logic              ovr_evt
);
  rx_flags_t         flags_q;
  logic [DATA_W-1:0] buf_q;
  logic              eff_full;

  assign eff_full = flags_q.full & ~clr.full;
  assign load_evt = byte_done & ~eff_full;
  assign ovr_evt  = byte_done & eff_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      buf_q   <= '0;
    end else begin
      if (load_evt) begin
        flags_q.full <= 1'b1;
        buf_q        <= byte_in;
      end else if (clr.full) begin
        flags_q.full <= 1'b0;
      end
      if (ovr_evt)      flags_q.ovr <= 1'b1;
      else if (clr.ovr) flags_q.ovr <= 1'b0;
    end
  end

  assign flags  = flags_q;
  assign rx_buf = buf_q;

  assert_load_sets_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (flags_q.full && buf_q == $past(byte_in)));
  assert_overflow_keeps_buf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (flags_q.ovr && buf_q == $past(buf_q)));
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.full && !clr.full) |=> flags_q.full);
  assert_ovr_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.ovr && !clr.ovr) |=> flags_q.ovr);
  assert_same_cycle_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && clr.full) |=> (flags_q.full && buf_q == $past(byte_in)));
endmodule

// File: rtl/spi_rxs_irq.sv
module spi_rxs_irq
  import spi_rxs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rx_flags_t flags,
  input  logic      fault_in,
  input  logic      rie,
  input  logic      eie,
  output logic      irq
);
  assign irq = irq_of(flags.full, flags.ovr, fault_in, rie, eie);

  assert_err_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!eie && !(flags.full && rie)) |-> !irq);
  assert_rx_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rie && !eie) |-> !irq);
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fault_in,
  output logic              irq
);
  localparam int PAD_W = DATA_W - 8;

  logic      st_rd, dt_rd, st_wr;
  rx_flags_t flags, clr;
  logic [DATA_W-1:0] rx_buf;
  logic      load_evt, ovr_evt;
  logic      rie_q, eie_q;
  logic [7:0] status_img;
  logic      unused_wbits;

  assign st_rd = bus_rd & ~bus_wr & (bus_addr == SEL_STATUS);
  assign dt_rd = bus_rd & ~bus_wr & (bus_addr == SEL_DATA);
  assign st_wr = bus_wr & (bus_addr == SEL_STATUS);
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rie_q <= 1'b0;
      eie_q <= 1'b0;
    end else if (st_wr) begin
      rie_q <= bus_wdata[ST_RIE_BIT];
      eie_q <= bus_wdata[ST_EIE_BIT];
    end
  end

  spi_rxs_arm u_arm (
    .clk(clk), .rst_n(rst_n), .st_rd(st_rd), .dt_rd(dt_rd),
    .any_wr(bus_wr), .flags(flags), .clr(clr)
  );

  spi_rxs_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_in(byte_in),
    .clr(clr), .flags(flags), .rx_buf(rx_buf),
    .load_evt(load_evt), .ovr_evt(ovr_evt)
  );

  spi_rxs_irq u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flags), .fault_in(fault_in),
    .rie(rie_q), .eie(eie_q), .irq(irq)
  );

  assign status_img = pack_status(flags.full, flags.ovr, fault_in, eie_q, rie_q);

  generate
    if (PAD_W > 0) begin : g_pad
      assign bus_rdata = (bus_addr == SEL_DATA) ? rx_buf : {{PAD_W{1'b0}}, status_img};
    end else begin : g_nopad
      assign bus_rdata = (bus_addr == SEL_DATA) ? rx_buf : status_img;
    end
  endgenerate

  assert_events_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({load_evt, ovr_evt}) <= 1);
  assert_enable_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> (rie_q == $past(bus_wdata[ST_RIE_BIT]) && eie_q == $past(bus_wdata[ST_EIE_BIT])));
endmodule

// File: tb/spi_rx_status_bench.sv
module spi_rx_status_bench;
  localparam int DATA_W = 8;
  localparam logic [2:0] OP_BYTE = 3'd1, OP_RST = 3'd2, OP_RDT = 3'd3,
                         OP_WST = 3'd4, OP_WDT = 3'd5;
  localparam int NV = 37;
  // fields: op[23:21] arg[20:13] expected read[12:5] expected irq[4] requirement[3:0]
  localparam logic [23:0] VEC [NV] = '{
    {OP_WST, 8'h03, 8'h00, 1'b0, 4'd10}, // R10 enable write
    {OP_RST, 8'h00, 8'h03, 1'b0, 4'd10}, // R10 layout
    {OP_BYTE,8'hA5, 8'h00, 1'b0, 4'd1},  // R1
    {OP_RST, 8'h00, 8'h83, 1'b1, 4'd1},  // R1 full, R7 irq
    {OP_RDT, 8'h00, 8'hA5, 1'b1, 4'd3},  // R3 clears full
    {OP_RST, 8'h00, 8'h03, 1'b0, 4'd3},
    {OP_BYTE,8'h11, 8'h00, 1'b0, 4'd1},
    {OP_BYTE,8'h22, 8'h00, 1'b1, 4'd2},  // R2 overflow
    {OP_RDT, 8'h00, 8'h11, 1'b1, 4'd6},  // R6 nothing armed
    {OP_RST, 8'h00, 8'hC3, 1'b1, 4'd2},
    {OP_WDT, 8'h00, 8'h00, 1'b1, 4'd6},  // R6 write disarms
    {OP_RDT, 8'h00, 8'h11, 1'b1, 4'd6},
    {OP_RST, 8'h00, 8'hC3, 1'b1, 4'd6},
    {OP_RDT, 8'h00, 8'h11, 1'b1, 4'd4},  // R4 clears both
    {OP_RST, 8'h00, 8'h03, 1'b0, 4'd4},
    {OP_WST, 8'h02, 8'h00, 1'b0, 4'd10},
    {OP_BYTE,8'h33, 8'h00, 1'b0, 4'd7},
    {OP_RST, 8'h00, 8'h82, 1'b0, 4'd7},  // R7 receive gated off
    {OP_BYTE,8'h44, 8'h00, 1'b0, 4'd7},
    {OP_RST, 8'h00, 8'hC2, 1'b1, 4'd8},  // R8 overflow via error enable
    {OP_WST, 8'h00, 8'h00, 1'b1, 4'd8},
    {OP_RST, 8'h00, 8'hC0, 1'b0, 4'd8},
    {OP_RDT, 8'h00, 8'h33, 1'b0, 4'd4},
    {OP_RST, 8'h00, 8'h00, 1'b0, 4'd3},
    {OP_RST, 8'h00, 8'h00, 1'b0, 4'd5},
    {OP_BYTE,8'h55, 8'h00, 1'b0, 4'd5},
    {OP_RDT, 8'h00, 8'h55, 1'b0, 4'd5},  // R5 full rose after status read
    {OP_RST, 8'h00, 8'h80, 1'b0, 4'd5},
    {OP_RDT, 8'h00, 8'h55, 1'b0, 4'd3},
    {OP_RST, 8'h00, 8'h00, 1'b0, 4'd3},
    {OP_BYTE,8'h66, 8'h00, 1'b0, 4'd1},
    {OP_RST, 8'h00, 8'h80, 1'b0, 4'd5},
    {OP_BYTE,8'h77, 8'h00, 1'b0, 4'd2},
    {OP_RDT, 8'h00, 8'h66, 1'b0, 4'd5},  // R5 only full armed
    {OP_RST, 8'h00, 8'h40, 1'b0, 4'd5},
    {OP_RDT, 8'h00, 8'h66, 1'b0, 4'd4},
    {OP_RST, 8'h00, 8'h00, 1'b0, 4'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0, byte_done = 1'b0, bus_addr = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, fault_in = 1'b0, irq;
  logic [DATA_W-1:0] byte_in = '0, bus_wdata = '0, bus_rdata;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_rx_status #(.DATA_W(DATA_W)) u_spi_rx_status (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_in(byte_in),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fault_in(fault_in), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Drive one access at the falling edge, sample before the rising edge.
  task automatic op(input logic [2:0] kind, input logic [7:0] arg, input logic bd,
                    input logic [7:0] bd_val, output logic [7:0] rd, output logic iq);
    @(negedge clk);
    byte_done = (kind == OP_BYTE) | bd;
    byte_in   = (kind == OP_BYTE) ? arg : bd_val;
    bus_rd    = (kind == OP_RST) | (kind == OP_RDT);
    bus_wr    = (kind == OP_WST) | (kind == OP_WDT);
    bus_addr  = (kind == OP_RDT) | (kind == OP_WDT);
    bus_wdata = arg;
    #1;
    rd = bus_rdata;
    iq = irq;
    @(posedge clk);
    #1;
    byte_done = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    logic iq;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9 reset state
    op(OP_RST, 8'h00, 1'b0, 8'h00, rd, iq); check("R9 status", rd, 8'h00);
    check("R9 irq", {7'd0, iq}, 8'h00);
    op(OP_RDT, 8'h00, 1'b0, 8'h00, rd, iq); check("R9 data", rd, 8'h00);
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string tag;
      v = VEC[i];
      op(v[23:21], v[20:13], 1'b0, 8'h00, rd, iq);
      tag = $sformatf("R%0d step %0d", v[3:0], i);
      if (v[23:21] == OP_RST || v[23:21] == OP_RDT) check(tag, rd, v[12:5]);
      check({tag, " irq"}, {7'd0, iq}, {7'd0, v[4]});
    end
    // R8 fault shares the error enable; R10 bit 4
    fault_in = 1'b1;
    op(OP_RST, 8'h00, 1'b0, 8'h00, rd, iq); check("R8 fault gated off", {7'd0, iq}, 8'h00);
    check("R10 fault bit", rd, 8'h10);
    op(OP_WST, 8'h02, 1'b0, 8'h00, rd, iq);
    op(OP_RST, 8'h00, 1'b0, 8'h00, rd, iq); check("R8 fault irq", {7'd0, iq}, 8'h01);
    op(OP_WST, 8'h01, 1'b0, 8'h00, rd, iq);
    op(OP_RST, 8'h00, 1'b0, 8'h00, rd, iq); check("R8 fault needs error enable", {7'd0, iq}, 8'h00);
    fault_in = 1'b0;
    // R11 byte in the same cycle as the clearing data read
    op(OP_BYTE, 8'h12, 1'b0, 8'h00, rd, iq);
    op(OP_RST, 8'h00, 1'b0, 8'h00, rd, iq); check("R11 pre", rd, 8'h81);
    op(OP_RDT, 8'h00, 1'b1, 8'h99, rd, iq); check("R11 old byte", rd, 8'h12);
    op(OP_RST, 8'h00, 1'b0, 8'h00, rd, iq); check("R11 no overflow", rd, 8'h81);
    op(OP_RDT, 8'h00, 1'b0, 8'h00, rd, iq); check("R11 new byte", rd, 8'h99);
    // R9 reset from a busy state
    op(OP_BYTE, 8'h5A, 1'b0, 8'h00, rd, iq);
    op(OP_WST, 8'h03, 1'b0, 8'h00, rd, iq);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    op(OP_RST, 8'h00, 1'b0, 8'h00, rd, iq); check("R9 status after reset", rd, 8'h00);
    check("R9 irq after reset", {7'd0, iq}, 8'h00);
    op(OP_RDT, 8'h00, 1'b0, 8'h00, rd, iq); check("R9 buffer after reset", rd, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule